// File: doc/BRIEF.md
# Multi-Mode Parallel Host Bus Front End

This block lets an external processor read and write a bank of up to 256 internal byte-addressed registers over a parallel bus. Three bus styles are accepted. Two have separate address lines: one style uses a data strobe plus a read/write level, and the other uses separate active-low read and write strobes. The third style carries the address on the low data lines. It is latched by an address-latch pin and then followed by a 32-bit data phase with byte enables.

The bus style is not configured by software. The block finds it from the address-latch pin. While reset is held, the block follows the level of that pin. When reset is released, a high level selects the strobe/read-write style and a low level selects the split read/write-strobe style. After reset, the first rising edge on the pin switches the block into the multiplexed style, and it stays there until the next reset.

All bus inputs are brought into the internal clock through synchronizers. Each bus access becomes a single-cycle internal write or read pulse, with a registered address, write data and byte enables. Read data from the register bank is returned on a separate data output, with an output-enable signal that models the tri-state driver.

Top module: `hostbus_front`

## Requirements
- R1: While reset is held the block follows the synchronized address-latch level. At release, a high level selects the strobe/read-write style and a low level selects the split-strobe style.
- R2: In the strobe/read-write style, a write needs chip select and data strobe both low with read/write low. A read needs chip select and data strobe low with read/write high. With the data strobe high there is no access, whatever read/write does.
- R3: In the split-strobe and multiplexed styles, a write is chip select low with the write strobe low. A read is chip select low with the read strobe low and the write strobe high.
- R4: Each access produces exactly one reg_wr or reg_rd pulse of one clock cycle, however long the strobe is held. reg_wr and reg_rd are never high together. With chip select high no pulse is produced.
- R5: In the two non-multiplexed styles, reg_addr is taken from bus_addr. The top data byte lane (bits 31:24) of reg_wdata and bus_d_out is forced to zero, and reg_be[3] is forced to 0. reg_be is the inverse of the active-low bus_be_n.
- R6: The first rising edge of bus_ale after reset switches the block into the multiplexed style. Later levels and edges of bus_ale do not switch it back before the next reset.
- R7: Edges on bus_ale while reset is held do not select the multiplexed style.
- R8: In the multiplexed style, reg_addr is the value of bus_d_in[7:0] captured at the falling edge of bus_ale, and bus_addr is ignored. All four byte lanes and all four byte enables pass through.
- R9: bus_d_oe is high only while chip select and the read condition hold, and it is low otherwise. While it is high, bus_d_out carries reg_rdata for the addressed register, with the top lane masked as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ctl_a_n | input | 1 | Data strobe (strobe/read-write style) or read strobe (other styles) |
| bus_ctl_b_n | input | 1 | Read/write level, high = read (strobe/read-write style), or write strobe (other styles) |
| bus_ale | input | 1 | Address-latch pin and bus style selector |
| bus_addr | input | 8 | Dedicated address lines for the non-multiplexed styles |
| bus_d_in | input | 32 | Bus data in; bits 7:0 also carry the multiplexed address |
| bus_be_n | input | 4 | Byte enables, active low |
| bus_d_out | output | 32 | Read data driven to the bus |
| bus_d_oe | output | 1 | Output enable for bus_d_out |
| reg_addr | output | 8 | Register address of the current access |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte enables, active high |
| reg_wr | output | 1 | Single-cycle write pulse |
| reg_rd | output | 1 | Single-cycle read pulse |
| reg_rdata | input | 32 | Read data from the register bank for reg_addr |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 32-bit data path and two synchronizer stages. With these values every register address is reachable, the masking of the fourth byte lane in the non-multiplexed styles is visible, and the three-cycle delay from strobe to internal pulse is short enough to hold strobes well past it. This shows that a long strobe still gives only one pulse. Across several resets with different address-latch levels, and with address-latch edges placed inside reset, the bench reaches all three bus styles and the one-way switch into the multiplexed style.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    BUS_STROBE_RW  = 2'd0,
    BUS_SPLIT_RDWR = 2'd1,
    BUS_MUXED      = 2'd2
  } bus_mode_e;
  localparam int LANE_W = 8;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) st[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) st[g] <= st[g-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbi_mode_ctl.sv
module hbi_mode_ctl
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] dlo_s,
  output bus_mode_e         mode,
  output logic [ADDR_W-1:0] mux_addr
);
  logic ale_q;

  always_ff @(posedge clk) begin
    ale_q <= ale_s;
    if (rst) begin
      // follow the static level; edges here are not acted on
      mode     <= ale_s ? BUS_STROBE_RW : BUS_SPLIT_RDWR;
      mux_addr <= '0;
    end else begin
      if (mode != BUS_MUXED && ale_s && !ale_q)
        mode <= BUS_MUXED;
      if (mode == BUS_MUXED && !ale_s && ale_q)
        mux_addr <= dlo_s;
    end
  end
endmodule

// File: rtl/hbi_access.sv
module hbi_access
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_mode_e         mode,
  input  logic              cs_n_s,
  input  logic              ca_n_s,
  input  logic              cb_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [ADDR_W-1:0] mux_addr,
  input  logic [DATA_W-1:0] d_s,
  input  logic [DATA_W/8-1:0] be_n_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W/8-1:0] reg_be,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe
);
  localparam int BE_W = DATA_W / 8;
  localparam int TOP  = DATA_W - LANE_W;

  logic wr_c, rd_c, wr_q, rd_q, wide;
  logic [DATA_W-1:0] wd_m, rd_m;
  logic [BE_W-1:0]   be_m;

  always_comb begin
    wide = (mode == BUS_MUXED);
    if (mode == BUS_STROBE_RW) begin
      wr_c = !cs_n_s && !ca_n_s && !cb_n_s;
      rd_c = !cs_n_s && !ca_n_s &&  cb_n_s;
    end else begin
      wr_c = !cs_n_s && !cb_n_s;
      rd_c = !cs_n_s && !ca_n_s && cb_n_s;
    end
    wd_m = d_s;
    rd_m = rdata;
    be_m = ~be_n_s;
    if (!wide) begin
      wd_m[DATA_W-1:TOP] = '0;
      rd_m[DATA_W-1:TOP] = '0;
      be_m[BE_W-1]       = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_be    <= '0;
      d_out     <= '0;
      d_oe      <= 1'b0;
    end else begin
      wr_q   <= wr_c;
      rd_q   <= rd_c;
      reg_wr <= wr_c && !wr_q;
      reg_rd <= rd_c && !rd_q;
      if ((wr_c && !wr_q) || (rd_c && !rd_q)) begin
        reg_addr  <= wide ? mux_addr : addr_s;
        reg_wdata <= wd_m;
        reg_be    <= be_m;
      end
      d_oe  <= rd_c;
      d_out <= rd_c ? rd_m : '0;
    end
  end
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_cs_n,
  input  logic                bus_ctl_a_n,
  input  logic                bus_ctl_b_n,
  input  logic                bus_ale,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_d_in,
  input  logic [DATA_W/8-1:0] bus_be_n,
  output logic [DATA_W-1:0]   bus_d_out,
  output logic                bus_d_oe,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W/8-1:0] reg_be,
  output logic                reg_wr,
  output logic                reg_rd,
  input  logic [DATA_W-1:0]   reg_rdata
);
  localparam int BE_W = DATA_W / 8;
  localparam int IN_W = 4 + ADDR_W + DATA_W + BE_W;

  logic [IN_W-1:0]   raw, syn;
  logic              cs_s, ca_s, cb_s, ale_s;
  logic [ADDR_W-1:0] addr_s, mux_addr;
  logic [DATA_W-1:0] d_s;
  logic [BE_W-1:0]   be_s;
  bus_mode_e         mode_q;

  assign raw = {bus_cs_n, bus_ctl_a_n, bus_ctl_b_n, bus_ale, bus_addr, bus_d_in, bus_be_n};
  assign {cs_s, ca_s, cb_s, ale_s, addr_s, d_s, be_s} = syn;

  hbi_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d(raw), .q(syn)
  );

  hbi_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst), .ale_s(ale_s), .dlo_s(d_s[ADDR_W-1:0]),
    .mode(mode_q), .mux_addr(mux_addr)
  );

  hbi_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .mode(mode_q),
    .cs_n_s(cs_s), .ca_n_s(ca_s), .cb_n_s(cb_s),
    .addr_s(addr_s), .mux_addr(mux_addr), .d_s(d_s), .be_n_s(be_s),
    .rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_wr(reg_wr), .reg_rd(reg_rd),
    .d_out(bus_d_out), .d_oe(bus_d_oe)
  );
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
  import hbi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input bus_mode_e           mode,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [DATA_W/8-1:0] reg_be,
  input logic                bus_d_oe,
  input logic [DATA_W-1:0]   bus_d_out
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R4
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R4
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd)); // R4
  AST_MUX_STICKY: assert property (@(posedge clk) disable iff (rst) mode == BUS_MUXED |=> mode == BUS_MUXED); // R6
  AST_RST_NO_MUX: assert property (@(posedge clk) rst |=> mode != BUS_MUXED); // R7
  AST_NARROW_BE: assert property (@(posedge clk) disable iff (rst) (reg_wr && mode != BUS_MUXED) |-> !reg_be[DATA_W/8-1]); // R5
  AST_NARROW_DOUT: assert property (@(posedge clk) disable iff (rst) (bus_d_oe && mode != BUS_MUXED) |-> bus_d_out[DATA_W-1:DATA_W-8] == '0); // R9
endmodule

bind hostbus_front hbi_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_be(reg_be), .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out)
);

// File: tb/tb_hostbus_front.sv
`timescale 1ns/1ps
module tb_hostbus_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ca_n = 1'b1, cb_n = 1'b1, ale = 1'b0;
  logic [7:0]  baddr = '0;
  logic [31:0] din = '0;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] dout, wdata, rdata;
  logic        oe, wr, rd;
  logic [7:0]  raddr;
  logic [3:0]  rbe;

  int tests = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 0, tb_mux = 0;
  logic [7:0]  cap_addr;
  logic [31:0] cap_data;
  logic [3:0]  cap_be;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    return {~a, a, 8'h5A, a ^ 8'hC3};
  endfunction
  assign rdata = model_rd(raddr);

  hostbus_front dut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_ctl_a_n(ca_n), .bus_ctl_b_n(cb_n),
    .bus_ale(ale), .bus_addr(baddr), .bus_d_in(din), .bus_be_n(be_n),
    .bus_d_out(dout), .bus_d_oe(oe), .reg_addr(raddr), .reg_wdata(wdata),
    .reg_be(rbe), .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata)
  );

  always @(negedge clk) begin
    if (wr) begin wr_cnt++; cap_addr = raddr; cap_data = wdata; cap_be = rbe; end
    if (rd) begin rd_cnt++; cap_addr = raddr; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic ale_lvl);
    rst = 1'b1; ale = ale_lvl; cyc(6); rst = 1'b0; cyc(4);
  endtask

  task automatic put_addr(input logic [7:0] a, input logic [7:0] dummy_lines);
    if (tb_mux) begin
      baddr = dummy_lines; din = {24'h0, a}; ale = 1'b1; cyc(4); ale = 1'b0; cyc(4);
    end else baddr = a;
  endtask

  // write: strobe low on both styles (read/write low + strobe low, or write strobe low)
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ben, input bit moto);
    put_addr(a, ~a);
    din = d; be_n = ben; cyc(2);
    cs_n = 1'b0; cb_n = 1'b0; if (moto) ca_n = 1'b0;
    cyc(8);
    cs_n = 1'b1; ca_n = 1'b1; cb_n = 1'b1; cyc(5);
  endtask

  task automatic bus_read(input logic [7:0] a, input string req, output logic [31:0] got, output logic got_oe);
    put_addr(a, ~a);
    cyc(2); cs_n = 1'b0; ca_n = 1'b0; cb_n = 1'b1;
    cyc(8); got = dout; got_oe = oe;
    cs_n = 1'b1; ca_n = 1'b1; cyc(5);
    chk(oe == 1'b0, {req, " oe drops after read"}, {31'h0, oe}, 32'h0);
  endtask

  // {write, addr, data, be_n}
  localparam logic [44:0] VEC [0:5] = '{
    {1'b1, 8'h03, 32'hA1B2C3D4, 4'b0000},
    {1'b1, 8'hFF, 32'h11223344, 4'b1010},
    {1'b0, 8'h03, 32'h0,        4'b1111},
    {1'b1, 8'h00, 32'hDEADBEEF, 4'b0111},
    {1'b0, 8'hFF, 32'h0,        4'b1111},
    {1'b0, 8'h80, 32'h0,        4'b1111}
  };

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int w0, r0;
    logic [31:0] got;
    logic got_oe;

    // reset state, split-strobe style (R1)
    do_reset(1'b0);
    chk(!wr && !rd && !oe, "R1 reset outputs idle", {29'h0, wr, rd, oe}, 32'h0);

    foreach (VEC[i]) begin
      logic [44:0] v = VEC[i];
      w0 = wr_cnt; r0 = rd_cnt;
      if (v[44]) begin
        bus_write(v[43:36], v[35:4], v[3:0], 1'b0);
        chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R3/R4 one write pulse", wr_cnt - w0, 1);
        chk(cap_addr == v[43:36], "R5 addr from address lines", cap_addr, v[43:36]);
        chk(cap_data == {8'h0, v[27:4]}, "R5 top lane masked", cap_data, {8'h0, v[27:4]});
        chk(cap_be == {1'b0, ~v[2:0]}, "R5 byte enables", cap_be, {1'b0, ~v[2:0]});
      end else begin
        bus_read(v[43:36], "R9", got, got_oe);
        chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R3/R4 one read pulse", rd_cnt - r0, 1);
        chk(got_oe && got == {8'h0, model_rd(v[43:36])[23:0]}, "R9 read data",
            got, {8'h0, model_rd(v[43:36])[23:0]});
      end
    end

    // chip select high: no access (R4)
    w0 = wr_cnt; baddr = 8'h44; cyc(2); cb_n = 1'b0; cyc(8); cb_n = 1'b1; cyc(5);
    chk(wr_cnt == w0 && !oe, "R4 no pulse with chip select high", wr_cnt - w0, 0);
    // split style: write strobe alone writes (R3)
    w0 = wr_cnt; bus_write(8'h21, 32'h00000077, 4'h0, 1'b0);
    chk(wr_cnt == w0 + 1, "R3 write strobe only", wr_cnt - w0, 1);

    // strobe/read-write style (R1, R2)
    do_reset(1'b1);
    w0 = wr_cnt; bus_write(8'h5A, 32'h00C0FFEE, 4'h0, 1'b1);
    chk(wr_cnt == w0 + 1 && cap_addr == 8'h5A, "R2 write with strobe and rw low", cap_addr, 8'h5A);
    chk(cap_data == 32'h00C0FFEE, "R2 write data", cap_data, 32'h00C0FFEE);
    w0 = wr_cnt; bus_write(8'h5B, 32'h1, 4'h0, 1'b0); // rw low, data strobe high
    chk(wr_cnt == w0, "R2 no write while data strobe high", wr_cnt - w0, 0);
    r0 = rd_cnt; bus_read(8'h33, "R2", got, got_oe);
    chk(rd_cnt == r0 + 1 && got_oe && got == {8'h0, model_rd(8'h33)[23:0]}, "R2 read",
        got, {8'h0, model_rd(8'h33)[23:0]});

    // address-latch edges inside reset are ignored (R7)
    rst = 1'b1; ale = 1'b0; cyc(4); ale = 1'b1; cyc(4); ale = 1'b0; cyc(4); rst = 1'b0; cyc(4);
    w0 = wr_cnt; bus_write(8'h11, 32'hFF0000AB, 4'h0, 1'b0);
    chk(wr_cnt == w0 + 1 && cap_addr == 8'h11 && cap_data == 32'h000000AB,
        "R7 still non-multiplexed after edges in reset", cap_data, 32'h000000AB);

    // first rising edge after reset: multiplexed style (R6, R8)
    tb_mux = 1;
    w0 = wr_cnt; bus_write(8'h5C, 32'hCAFEF00D, 4'b0110, 1'b0);
    chk(wr_cnt == w0 + 1 && cap_addr == 8'h5C, "R8 latched address", cap_addr, 8'h5C);
    chk(cap_data == 32'hCAFEF00D, "R8 full 32-bit data", cap_data, 32'hCAFEF00D);
    chk(cap_be == 4'b1001, "R8 four byte enables", cap_be, 4'b1001);
    r0 = rd_cnt; bus_read(8'hE7, "R8", got, got_oe);
    chk(rd_cnt == r0 + 1 && got_oe && got == model_rd(8'hE7), "R8/R9 full read", got, model_rd(8'hE7));
    // stays multiplexed after further latch cycles (R6)
    w0 = wr_cnt; bus_write(8'h02, 32'h80000001, 4'h0, 1'b0);
    chk(cap_addr == 8'h02 && cap_data == 32'h80000001, "R6 multiplexed style sticks", cap_data, 32'h80000001);

    // new reset with low level returns to split style (R1)
    tb_mux = 0;
    do_reset(1'b0);
    w0 = wr_cnt; bus_write(8'h9D, 32'hFFFFFFFF, 4'h0, 1'b0);
    chk(cap_addr == 8'h9D && cap_data == 32'h00FFFFFF, "R1 split style after reset", cap_data, 32'h00FFFFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule